// File: doc/BRIEF.md
# Floating-Point NaN Result Selector

This block sits beside a floating-point datapath and settles one question for each operation: must the result be a NaN, and if so, which bit pattern. It looks at up to two operands, interprets them as 32-bit or 64-bit IEEE 754 values, and uses the operation class to pick a policy. Arithmetic operations either carry a quieted operand NaN forward or, under a mode bit, collapse every NaN outcome to one canonical pattern. Copy-style operations (plain move, absolute value, negate) and memory transfers move a NaN across untouched, except for the sign that a copy may rewrite.

The host pipeline drives the operand fields and control bits each cycle. One clock later the block presents a NaN-result strobe, the 64-bit result word and an invalid-operation indication. The host uses the word when the strobe is high and otherwise takes the result from its ordinary arithmetic path. Single-precision values live in the low half of the 64-bit path.

Top module: `nan_select_top`

## Requirements
- R1: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. With `dbl`=0 the exponent is bits [30:23] and the fraction bits [22:0], and bits [63:32] of the input are ignored. With `dbl`=1 the exponent is bits [62:52] and the fraction bits [51:0]. An infinity is not a NaN. A single-precision result has bits [63:32] zero.
- R2: A NaN whose top fraction bit (bit 22 single, bit 51 double) is 0 is signaling. When it is 1 the NaN is quiet.
- R3: For arithmetic with `dflt_nan`=0, the result is an operand NaN with its top fraction bit forced to 1. A signaling NaN is chosen over a quiet one. Between NaNs of the same kind, `op_a` is chosen.
- R4: For arithmetic with `dflt_nan`=1, any NaN operand gives the canonical NaN: 0x7FC00000 single or 0x7FF8000000000000 double.
- R5: `inv_flag` is 1 exactly when an arithmetic operation has a signaling NaN among the operands it uses, in either mode. Quiet-only NaNs leave it 0.
- R6: The copy class (`op_class`=1) looks only at `op_a` and returns its NaN without quieting and with `inv_flag`=0, in either mode. The sign is set by `sign_act`: 0 keep, 1 clear, 2 invert, 3 keep.
- R7: The transfer class (`op_class`=2) returns an `op_a` NaN bit for bit, with `inv_flag`=0, in either mode. `op_b` is ignored.
- R8: `op_class` 0 is arithmetic and 3 is reserved and never yields a NaN result. Whenever `nan_out` is 0, `result` and `inv_flag` are also 0.
- R9: An arithmetic operation with `two_ops`=0 ignores `op_b` entirely.
- R10: Outputs are registered and reflect the inputs of the previous rising edge. A synchronous active-high `rst` clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 64 | First operand (single in bits [31:0]) |
| op_b | input | 64 | Second operand (single in bits [31:0]) |
| dbl | input | 1 | 1 selects 64-bit interpretation, 0 selects 32-bit |
| two_ops | input | 1 | Arithmetic operation uses `op_b` |
| dflt_nan | input | 1 | Canonical-NaN mode for arithmetic |
| op_class | input | 2 | 0 arithmetic, 1 copy, 2 transfer, 3 reserved |
| sign_act | input | 2 | Copy sign action: 0 keep, 1 clear, 2 invert, 3 keep |
| nan_out | output | 1 | Result must be a NaN |
| result | output | 64 | NaN result word, zero when `nan_out` is 0 |
| inv_flag | output | 1 | Invalid-operation indication |

## Verification
Arithmetic is driven with a NaN in either operand slot, with quiet, signaling and mixed pairs, and with same-kind pairs. These cases separate the kind priority from the operand-order tie-break, and the quieting from plain forwarding. The same NaN patterns pass through copy and transfer classes with the mode bit set, which shows that neither class quiets or raises the flag. Non-NaN, infinity and upper-half-junk patterns in both precisions expose a wrong field slice. Unused-operand and reserved-class cases show that ignored inputs stay ignored.

// File: rtl/nan_sel_pkg.sv
package nan_sel_pkg;

    localparam int DW        = 64;
    localparam int SW        = 32;
    localparam int NUM_OPS   = 2;
    localparam int S_EXP_W   = 8;
    localparam int S_FRAC_W  = 23;
    localparam int D_EXP_W   = 11;
    localparam int D_FRAC_W  = 52;
    localparam int S_SIGN    = S_FRAC_W + S_EXP_W;
    localparam int D_SIGN    = D_FRAC_W + D_EXP_W;
    localparam int S_QBIT    = S_FRAC_W - 1;
    localparam int D_QBIT    = D_FRAC_W - 1;

    typedef enum logic [1:0] {
        OPC_ARITH = 2'd0,
        OPC_COPY  = 2'd1,
        OPC_XFER  = 2'd2,
        OPC_RSVD  = 2'd3
    } op_class_e;

    typedef enum logic [1:0] {
        SGN_KEEP  = 2'd0,
        SGN_CLEAR = 2'd1,
        SGN_FLIP  = 2'd2,
        SGN_KEEP2 = 2'd3
    } sign_act_e;

    typedef struct packed {
        logic          is_nan;
        logic          is_snan;
        logic [DW-1:0] view;
    } opnd_info_t;

    typedef struct packed {
        logic          nan;
        logic          inv;
        logic [DW-1:0] data;
    } nan_res_t;

    function automatic logic [DW-1:0] canon_nan(input logic dbl);
        logic [DW-1:0] w;
        w = '0;
        if (dbl) begin
            w[D_SIGN-1 -: D_EXP_W] = '1;
            w[D_QBIT]              = 1'b1;
        end else begin
            w[S_SIGN-1 -: S_EXP_W] = '1;
            w[S_QBIT]              = 1'b1;
        end
        return w;
    endfunction

    function automatic logic [DW-1:0] quieten(input logic [DW-1:0] w, input logic dbl);
        logic [DW-1:0] r;
        r = w;
        if (dbl) r[D_QBIT] = 1'b1;
        else     r[S_QBIT] = 1'b1;
        return r;
    endfunction

    function automatic logic [DW-1:0] apply_sign(input logic [DW-1:0] w, input logic dbl,
                                                  input sign_act_e act);
        logic [DW-1:0] r;
        r = w;
        case (act)
            SGN_CLEAR: if (dbl) r[D_SIGN] = 1'b0; else r[S_SIGN] = 1'b0;
            SGN_FLIP:  if (dbl) r[D_SIGN] = ~w[D_SIGN]; else r[S_SIGN] = ~w[S_SIGN];
            default:   r = w;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/nan_classify.sv
module nan_classify
    import nan_sel_pkg::*;
(
    input  logic [DW-1:0] word_i,
    input  logic          dbl_i,
    output opnd_info_t    info_o
);
    logic exp_ones;
    logic frac_nz;
    logic top_frac;

    always_comb begin
        if (dbl_i) begin
            exp_ones = &word_i[D_SIGN-1 -: D_EXP_W];
            frac_nz  = |word_i[D_FRAC_W-1:0];
            top_frac = word_i[D_QBIT];
        end else begin
            exp_ones = &word_i[S_SIGN-1 -: S_EXP_W];
            frac_nz  = |word_i[S_FRAC_W-1:0];
            top_frac = word_i[S_QBIT];
        end
    end

    always_comb begin
        info_o.is_nan  = exp_ones && frac_nz;
        info_o.is_snan = exp_ones && frac_nz && !top_frac;
        info_o.view    = dbl_i ? word_i : {{(DW-SW){1'b0}}, word_i[SW-1:0]};
    end
endmodule

// File: rtl/nan_pick.sv
module nan_pick
    import nan_sel_pkg::*;
(
    input  opnd_info_t info_a_i,
    input  opnd_info_t info_b_i,
    input  logic       use_b_i,
    output logic       any_nan_o,
    output logic       any_snan_o,
    output logic       pick_b_o
);
    logic b_nan;
    logic b_snan;

    always_comb begin
        b_nan      = use_b_i && info_b_i.is_nan;
        b_snan     = use_b_i && info_b_i.is_snan;
        any_nan_o  = info_a_i.is_nan || b_nan;
        any_snan_o = info_a_i.is_snan || b_snan;
        // b wins only if a is not a NaN, or b outranks a by kind
        pick_b_o   = b_nan && (!info_a_i.is_nan || (b_snan && !info_a_i.is_snan));
    end
endmodule

// File: rtl/nan_shape.sv
module nan_shape
    import nan_sel_pkg::*;
(
    input  op_class_e  cls_i,
    input  sign_act_e  sgn_i,
    input  logic       dbl_i,
    input  logic       dn_i,
    input  opnd_info_t info_a_i,
    input  opnd_info_t info_b_i,
    input  logic       any_nan_i,
    input  logic       any_snan_i,
    input  logic       pick_b_i,
    output nan_res_t   res_o
);
    logic [DW-1:0] chosen;

    always_comb begin
        chosen = pick_b_i ? info_b_i.view : info_a_i.view;
        res_o  = '0;
        case (cls_i)
            OPC_ARITH: begin
                if (any_nan_i) begin
                    res_o.nan  = 1'b1;
                    res_o.inv  = any_snan_i;
                    res_o.data = dn_i ? canon_nan(dbl_i) : quieten(chosen, dbl_i);
                end
            end
            OPC_COPY: begin
                if (info_a_i.is_nan) begin
                    res_o.nan  = 1'b1;
                    res_o.data = apply_sign(info_a_i.view, dbl_i, sgn_i);
                end
            end
            OPC_XFER: begin
                if (info_a_i.is_nan) begin
                    res_o.nan  = 1'b1;
                    res_o.data = info_a_i.view;
                end
            end
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/nan_select_top.sv
module nan_select_top
    import nan_sel_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [63:0]   op_a,
    input  logic [63:0]   op_b,
    input  logic          dbl,
    input  logic          two_ops,
    input  logic          dflt_nan,
    input  logic [1:0]    op_class,
    input  logic [1:0]    sign_act,
    output logic          nan_out,
    output logic [63:0]   result,
    output logic          inv_flag
);
    logic [DW-1:0] opnd [NUM_OPS];
    opnd_info_t    info [NUM_OPS];
    logic          any_nan;
    logic          any_snan;
    logic          pick_b;
    logic          use_b;
    nan_res_t      nxt;
    nan_res_t      cur;

    assign opnd[0] = op_a;
    assign opnd[1] = op_b;

    generate
        for (genvar k = 0; k < NUM_OPS; k++) begin : g_cls
            nan_classify u_cls (
                .word_i (opnd[k]),
                .dbl_i  (dbl),
                .info_o (info[k])
            );
        end
    endgenerate

    assign use_b = two_ops && (op_class_e'(op_class) == OPC_ARITH);

    nan_pick u_pick (
        .info_a_i   (info[0]),
        .info_b_i   (info[1]),
        .use_b_i    (use_b),
        .any_nan_o  (any_nan),
        .any_snan_o (any_snan),
        .pick_b_o   (pick_b)
    );

    nan_shape u_shape (
        .cls_i      (op_class_e'(op_class)),
        .sgn_i      (sign_act_e'(sign_act)),
        .dbl_i      (dbl),
        .dn_i       (dflt_nan),
        .info_a_i   (info[0]),
        .info_b_i   (info[1]),
        .any_nan_i  (any_nan),
        .any_snan_i (any_snan),
        .pick_b_i   (pick_b),
        .res_o      (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign nan_out  = cur.nan;
    assign result   = cur.data;
    assign inv_flag = cur.inv;
endmodule

// File: rtl/nan_select_chk.sv
module nan_select_chk
    import nan_sel_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [63:0] op_a,
    input logic        dbl,
    input logic        dflt_nan,
    input logic [1:0]  op_class,
    input logic        nan_out,
    input logic [63:0] result,
    input logic        inv_flag
);
    AST_INV_ARITH_ONLY: assert property (@(posedge clk) disable iff (rst)
        inv_flag |-> $past(op_class) == OPC_ARITH); // R5

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !nan_out |-> (result == '0 && !inv_flag)); // R8

    AST_SINGLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (nan_out && !$past(dbl)) |-> result[63:32] == '0); // R1

    AST_CANON_IN_DN: assert property (@(posedge clk) disable iff (rst)
        (nan_out && $past(dflt_nan) && $past(op_class) == OPC_ARITH)
        |-> result == ($past(dbl) ? 64'h7FF8_0000_0000_0000 : 64'h0000_0000_7FC0_0000)); // R4

    AST_ARITH_QUIET: assert property (@(posedge clk) disable iff (rst)
        (nan_out && $past(op_class) == OPC_ARITH)
        |-> ($past(dbl) ? result[51] : result[22])); // R3

    AST_XFER_EXACT: assert property (@(posedge clk) disable iff (rst)
        (nan_out && $past(op_class) == OPC_XFER)
        |-> result == ($past(dbl) ? $past(op_a) : {32'h0, $past(op_a[31:0])})); // R7

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!nan_out && !inv_flag && result == '0)); // R10
endmodule

bind nan_select_top nan_select_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_a     (op_a),
    .dbl      (dbl),
    .dflt_nan (dflt_nan),
    .op_class (op_class),
    .nan_out  (nan_out),
    .result   (result),
    .inv_flag (inv_flag)
);

// File: tb/tb_nan_select_top.sv
module tb_nan_select_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        dbl = 1'b0;
    logic        two_ops = 1'b0;
    logic        dflt_nan = 1'b0;
    logic [1:0]  op_class = 2'd0;
    logic [1:0]  sign_act = 2'd0;
    logic        nan_out;
    logic [63:0] result;
    logic        inv_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    nan_select_top dut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .dbl(dbl),
        .two_ops(two_ops), .dflt_nan(dflt_nan), .op_class(op_class),
        .sign_act(sign_act), .nan_out(nan_out), .result(result), .inv_flag(inv_flag)
    );

    typedef struct packed {
        logic        dbl;
        logic        two;
        logic        dn;
        logic [1:0]  cls;
        logic [1:0]  sgn;
        logic [63:0] a;
        logic [63:0] b;
        logic        en;
        logic [63:0] er;
        logic        ei;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        // R3 quiet a propagates
        '{1'b0,1'b1,1'b0,2'd0,2'd0,64'h7FC00005,64'h3F800000,1'b1,64'h7FC00005,1'b0,8'd3},
        // R2 R5 signaling b quieted, flag
        '{1'b0,1'b1,1'b0,2'd0,2'd0,64'h3F800000,64'h7F800001,1'b1,64'h7FC00001,1'b1,8'd5},
        // R3 signaling beats quiet
        '{1'b0,1'b1,1'b0,2'd0,2'd0,64'h7FC00005,64'h7F800002,1'b1,64'h7FC00002,1'b1,8'd3},
        // R3 both signaling: a wins
        '{1'b0,1'b1,1'b0,2'd0,2'd0,64'h7F800003,64'h7F800002,1'b1,64'h7FC00003,1'b1,8'd3},
        // R3 R5 both quiet: a wins, no flag
        '{1'b0,1'b1,1'b0,2'd0,2'd0,64'h7FC00005,64'hFFC00009,1'b1,64'h7FC00005,1'b0,8'd3},
        // R4 quiet in canonical mode
        '{1'b0,1'b1,1'b1,2'd0,2'd0,64'h7FC00005,64'h3F800000,1'b1,64'h7FC00000,1'b0,8'd4},
        // R4 R5 signaling in canonical mode
        '{1'b0,1'b1,1'b1,2'd0,2'd0,64'h3F800000,64'hFF800001,1'b1,64'h7FC00000,1'b1,8'd5},
        // R4 double canonical
        '{1'b1,1'b1,1'b1,2'd0,2'd0,64'hFFF0000000000001,64'h0,1'b1,64'h7FF8000000000000,1'b1,8'd4},
        // R3 double quieting
        '{1'b1,1'b1,1'b0,2'd0,2'd0,64'h7FF0000000000001,64'h3FF0000000000000,1'b1,64'h7FF8000000000001,1'b1,8'd3},
        // R1 infinity is not NaN
        '{1'b0,1'b1,1'b0,2'd0,2'd0,64'h3F800000,64'h7F800000,1'b0,64'h0,1'b0,8'd1},
        // R9 unused b ignored
        '{1'b0,1'b0,1'b0,2'd0,2'd0,64'h3F800000,64'h7F800001,1'b0,64'h0,1'b0,8'd9},
        // R6 copy negate, signaling kept, no flag
        '{1'b0,1'b0,1'b1,2'd1,2'd2,64'h7F800001,64'h0,1'b1,64'hFF800001,1'b0,8'd6},
        // R6 copy abs
        '{1'b0,1'b0,1'b0,2'd1,2'd1,64'hFFC00004,64'h0,1'b1,64'h7FC00004,1'b0,8'd6},
        // R6 copy keep double
        '{1'b1,1'b0,1'b0,2'd1,2'd0,64'hFFF0000000000007,64'h0,1'b1,64'hFFF0000000000007,1'b0,8'd6},
        // R6 copy ignores b NaN
        '{1'b0,1'b1,1'b0,2'd1,2'd0,64'h3F800000,64'h7F800001,1'b0,64'h0,1'b0,8'd6},
        // R7 transfer single, canonical mode on
        '{1'b0,1'b0,1'b1,2'd2,2'd2,64'hFF800009,64'h0,1'b1,64'hFF800009,1'b0,8'd7},
        // R7 transfer double signaling
        '{1'b1,1'b1,1'b0,2'd2,2'd0,64'h7FF0000000000001,64'h7FF0000000000001,1'b1,64'h7FF0000000000001,1'b0,8'd7},
        // R1 single ignores upper half
        '{1'b0,1'b1,1'b0,2'd0,2'd0,64'hDEADBEEF7FC00005,64'hFFFFFFFF00000000,1'b1,64'h000000007FC00005,1'b0,8'd1},
        // R1 double view of a single NaN pattern is not NaN
        '{1'b1,1'b1,1'b0,2'd0,2'd0,64'h000000007FC00005,64'h0,1'b0,64'h0,1'b0,8'd1},
        // R8 reserved class
        '{1'b0,1'b1,1'b0,2'd3,2'd0,64'h7F800001,64'h7F800001,1'b0,64'h0,1'b0,8'd8}
    };

    task automatic chk(input string tag, input logic en, input logic [63:0] er, input logic ei);
        checks++;
        if (nan_out !== en || result !== er || inv_flag !== ei) begin
            fails++;
            $display("FAIL %s: got nan=%0b res=%h inv=%0b, expected nan=%0b res=%h inv=%0b",
                     tag, nan_out, result, inv_flag, en, er, ei);
        end
    endtask

    task automatic drive(input vec_t v);
        dbl = v.dbl; two_ops = v.two; dflt_nan = v.dn; op_class = v.cls;
        sign_act = v.sgn; op_a = v.a; op_b = v.b;
    endtask

    initial begin
        // R10 reset clears outputs even with NaN inputs present
        drive(VECS[1]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset", 1'b0, 64'h0, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(negedge clk);
            chk($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].en, VECS[i].er, VECS[i].ei);
        end

        // R6 sign action 3 keeps the sign
        @(negedge clk);
        dbl = 1'b0; op_class = 2'd1; sign_act = 2'd3; op_a = 64'hFF800005; two_ops = 1'b0;
        @(negedge clk);
        chk("R6 sign keep code 3", 1'b1, 64'hFF800005, 1'b0);

        // R10 one-cycle latency: input change not visible before the edge
        op_class = 2'd0; dflt_nan = 1'b0; op_a = 64'h3F800000; op_b = 64'h0;
        @(negedge clk);
        op_a = 64'h7F800007;
        #1;
        chk("R10 before edge", 1'b0, 64'h0, 1'b0);
        @(negedge clk);
        chk("R10 after edge", 1'b1, 64'h7FC00007, 1'b1);

        // R10 synchronous reset mid-run
        rst = 1'b1;
        @(negedge clk);
        chk("R10 mid reset", 1'b0, 64'h0, 1'b0);
        rst = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule